// File: doc/BRIEF.md
# Four-Mode Down-Counting Timer with Watchdog Reset Request

This block is a single 16-bit down-counter with a register bus. A shared prescaler slows the counter, and the same counter serves four behaviours. Free-running mode wraps around. Periodic mode reloads and raises an interrupt. One-shot mode raises an interrupt and then disables itself. Watchdog mode asks the system for a reset.

Software programs the block in three steps. First it writes the mode and divider into the control word with the enable bit clear. Next it writes a start value into the load register. Last it sets the enable bit. In watchdog mode, software keeps the system alive by rewriting the load register before the count runs out.

A missed keepalive produces a one-cycle reset request and sets a sticky cause flag. The flag survives the synchronous system reset that the request triggers, so software can read it after restart. Only a write of one to the flag or a power-on reset clears it.

Top module: `mt_timer`

## Requirements
- R1: After power-on reset (`rst_ni` low), reads of every offset return 0, and `irq_o` and `wdt_rst_req_o` are low.
- R2: A bus write to offset 0x00 sets both the reload value and the counter to `wdata[15:0]` on the same edge, and write bits above 15 are dropped. A read of offset 0x00 returns the live counter value in bits 15:0.
- R3: Offset 0x08 is the control word: bit 7 enable, bits 5:4 mode (0 free-running, 1 periodic, 2 one-shot, 3 watchdog), bits 3:0 divider code. The other bits read as 0. While enable is 0 and no load write occurs, the counter holds its value.
- R4: Divider code k in 0..14 gives one counter step every 2^k clock cycles, and code 15 gives one step every 65536 cycles. The first step comes 2^k cycles after the edge that sets enable, because the divider restarts whenever the timer is disabled.
- R5: Free-running mode: a step taken at count 0 wraps the counter to 0xFFFF, and no interrupt is raised.
- R6: Periodic mode: a step taken at count 0 reloads the counter from the reload value, and `irq_o` is high for the single following cycle.
- R7: One-shot mode: a step taken at count 0 pulses `irq_o` for one cycle and clears the enable bit. The counter stays at 0.
- R8: Watchdog mode: a step taken at count 0 pulses `wdt_rst_req_o` for one cycle, sets the cause flag (bit 5 of offset 0x04), and reloads the counter from the reload value.
- R9: In watchdog mode, rewriting offset 0x00 more often than the count period prevents any reset request.
- R10: Writing 1 to bit 5 of offset 0x04 clears the cause flag, and writing 0 has no effect. A set on the same edge wins over a clear. `sys_rst_i` clears all other state but keeps the flag.
- R11: A bus write on the same edge as an expiry overrides the expiry's effect on the counter (load write) or on enable (control write). The pulse that the expiry raises is still issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset; clears everything |
| sys_rst_i | input | 1 | Synchronous system reset; clears all but the cause flag |
| bus_sel_i | input | 1 | Bus access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W (4) | Byte offset: 0x00 load/count, 0x04 status, 0x08 control |
| bus_wdata_i | input | DATA_W (32) | Write data |
| bus_rdata_o | output | DATA_W (32) | Combinational read data, 0 when not reading |
| irq_o | output | 1 | One-cycle interrupt pulse (periodic and one-shot) |
| wdt_rst_req_o | output | 1 | One-cycle system reset request (watchdog) |

## Verification
The bound checker enforces several properties on every cycle:
- an interrupt only follows an enabled periodic or one-shot cycle;
- a reset request only follows an enabled watchdog cycle, and the cause flag is then set;
- the flag only falls after a write-one-to-clear;
- enable only drops through a control write, a one-shot expiry or a system reset;
- a disabled counter stays still.

Other behaviours only the bench's scenarios can show:
- exact step timing per divider code, including the 65536 code;
- wrap and reload values;
- keepalive that prevents a reset;
- write-versus-expiry priority;
- the flag surviving a system reset.

The behavioural model compares read data and both pulse outputs on every clock to establish these.

// File: rtl/mt_pkg.sv
package mt_pkg;
    typedef enum logic [1:0] {
        MODE_FREE     = 2'd0,
        MODE_PERIODIC = 2'd1,
        MODE_ONESHOT  = 2'd2,
        MODE_WDOG     = 2'd3
    } mode_e;

    localparam int OFF_LOAD  = 'h00;
    localparam int OFF_STAT  = 'h04;
    localparam int OFF_CTRL  = 'h08;

    localparam int BIT_EN    = 7;
    localparam int MODE_LSB  = 4;
    localparam int CAUSE_BIT = 5;
endpackage

// File: rtl/mt_prescaler.sv
module mt_prescaler #(
    parameter int PSC_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             run_i,
    input  logic [PSC_W-1:0] code_i,
    output logic             tick_o
);
    localparam int PCNT_W = 2 ** PSC_W;
    localparam logic [PSC_W-1:0] TOP_CODE = '1;

    logic [PCNT_W-1:0] pcnt_d, pcnt_q;
    logic [PCNT_W-1:0] mask;

    // Top code selects the full counter width; others select 2^code.
    always_comb begin
        mask = '0;
        if (code_i == TOP_CODE) begin
            mask = '1;
        end else begin
            for (int k = 0; k < PCNT_W; k++) begin
                if (k < int'(code_i)) mask[k] = 1'b1;
            end
        end
    end

    assign tick_o = run_i && ((pcnt_q & mask) == mask);

    always_comb begin
        pcnt_d = pcnt_q + 1'b1;
        if (clr_i || !run_i) pcnt_d = '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pcnt_q <= '0;
        else         pcnt_q <= pcnt_d;
    end
endmodule

// File: rtl/mt_regif.sv
module mt_regif
    import mt_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16,
    parameter int PSC_W  = 4
) (
    input  logic              sel_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              en_i,
    input  mode_e             mode_i,
    input  logic [PSC_W-1:0]  psc_i,
    input  logic              flag_i,
    output logic              wr_load_o,
    output logic              wr_ctrl_o,
    output logic              wr_stat_o,
    output logic [DATA_W-1:0] rdata_o
);
    localparam logic [ADDR_W-1:0] A_LOAD = ADDR_W'(OFF_LOAD);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);

    logic wr_any;
    assign wr_any    = sel_i && wr_i;
    assign wr_load_o = wr_any && (addr_i == A_LOAD);
    assign wr_ctrl_o = wr_any && (addr_i == A_CTRL);
    assign wr_stat_o = wr_any && (addr_i == A_STAT);

    always_comb begin
        rdata_o = '0;
        if (sel_i && !wr_i) begin
            case (addr_i)
                A_LOAD: rdata_o[CNT_W-1:0] = count_i;
                A_STAT: rdata_o[CAUSE_BIT] = flag_i;
                A_CTRL: begin
                    rdata_o[BIT_EN]           = en_i;
                    rdata_o[MODE_LSB +: 2]    = mode_i;
                    rdata_o[PSC_W-1:0]        = psc_i;
                end
                default: rdata_o = '0;
            endcase
        end
    end
endmodule

// File: rtl/mt_core.sv
module mt_core
    import mt_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PSC_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             sys_rst_i,
    input  logic             tick_i,
    input  logic             wr_load_i,
    input  logic             wr_ctrl_i,
    input  logic             wr_stat_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic [CNT_W-1:0] count_o,
    output logic             en_o,
    output mode_e            mode_o,
    output logic [PSC_W-1:0] psc_o,
    output logic             flag_o,
    output logic             irq_o,
    output logic             wrst_o
);
    typedef struct packed {
        logic [CNT_W-1:0] load;
        logic [CNT_W-1:0] count;
        logic             en;
        mode_e            mode;
        logic [PSC_W-1:0] psc;
        logic             flag;
        logic             irq;
        logic             wrst;
    } core_t;

    core_t st_d, st_q;
    logic  keep_flag;

    always_comb begin
        st_d      = st_q;
        st_d.irq  = 1'b0;
        st_d.wrst = 1'b0;
        keep_flag = 1'b0;

        if (st_q.en && tick_i) begin
            if (st_q.count == '0) begin
                case (st_q.mode)
                    MODE_FREE: st_d.count = '1;
                    MODE_PERIODIC: begin
                        st_d.count = st_q.load;
                        st_d.irq   = 1'b1;
                    end
                    MODE_ONESHOT: begin
                        st_d.irq = 1'b1;
                        st_d.en  = 1'b0;
                    end
                    default: begin
                        st_d.wrst  = 1'b1;
                        st_d.flag  = 1'b1;
                        st_d.count = st_q.load;
                    end
                endcase
            end else begin
                st_d.count = st_q.count - 1'b1;
            end
        end

        // Bus writes override the expiry effect on the same edge.
        if (wr_load_i) begin
            st_d.load  = wdata_i;
            st_d.count = wdata_i;
        end
        if (wr_ctrl_i) begin
            st_d.en   = wdata_i[BIT_EN];
            st_d.mode = mode_e'(wdata_i[MODE_LSB +: 2]);
            st_d.psc  = wdata_i[PSC_W-1:0];
        end
        // Clear-by-one, a simultaneous set wins.
        if (wr_stat_i && wdata_i[CAUSE_BIT] && !st_d.wrst) st_d.flag = 1'b0;

        if (sys_rst_i) begin
            keep_flag = st_d.flag;
            st_d      = '0;
            st_d.flag = keep_flag;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign count_o = st_q.count;
    assign en_o    = st_q.en;
    assign mode_o  = st_q.mode;
    assign psc_o   = st_q.psc;
    assign flag_o  = st_q.flag;
    assign irq_o   = st_q.irq;
    assign wrst_o  = st_q.wrst;
endmodule

// File: rtl/mt_timer.sv
module mt_timer
    import mt_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16,
    parameter int PSC_W  = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              sys_rst_i,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_o,
    output logic              wdt_rst_req_o
);
    logic             wr_load, wr_ctrl, wr_stat, tick;
    logic [CNT_W-1:0] cnt_val;
    logic             ctrl_en, cause_flag;
    mode_e            ctrl_mode;
    logic [PSC_W-1:0] ctrl_psc;
    logic             wdata_hi_unused;

    assign wdata_hi_unused = ^bus_wdata_i[DATA_W-1:CNT_W];

    mt_regif #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .PSC_W(PSC_W)
    ) u_regif (
        .sel_i     (bus_sel_i),
        .wr_i      (bus_wr_i),
        .addr_i    (bus_addr_i),
        .count_i   (cnt_val),
        .en_i      (ctrl_en),
        .mode_i    (ctrl_mode),
        .psc_i     (ctrl_psc),
        .flag_i    (cause_flag),
        .wr_load_o (wr_load),
        .wr_ctrl_o (wr_ctrl),
        .wr_stat_o (wr_stat),
        .rdata_o   (bus_rdata_o)
    );

    mt_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (sys_rst_i),
        .run_i  (ctrl_en),
        .code_i (ctrl_psc),
        .tick_o (tick)
    );

    mt_core #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_core (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .sys_rst_i (sys_rst_i),
        .tick_i    (tick),
        .wr_load_i (wr_load),
        .wr_ctrl_i (wr_ctrl),
        .wr_stat_i (wr_stat),
        .wdata_i   (bus_wdata_i[CNT_W-1:0]),
        .count_o   (cnt_val),
        .en_o      (ctrl_en),
        .mode_o    (ctrl_mode),
        .psc_o     (ctrl_psc),
        .flag_o    (cause_flag),
        .irq_o     (irq_o),
        .wrst_o    (wdt_rst_req_o)
    );
endmodule

// File: rtl/mt_timer_chk.sv
module mt_timer_chk
    import mt_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sys_rst,
    input logic              sel,
    input logic              wr,
    input logic [ADDR_W-1:0] addr,
    input logic              wbit_cause,
    input logic              irq,
    input logic              wrst,
    input logic              en,
    input mode_e             mode,
    input logic [CNT_W-1:0]  count,
    input logic              flag
);
    logic w_load, w_ctrl, w_stat;
    assign w_load = sel && wr && (addr == ADDR_W'(OFF_LOAD));
    assign w_ctrl = sel && wr && (addr == ADDR_W'(OFF_CTRL));
    assign w_stat = sel && wr && (addr == ADDR_W'(OFF_STAT));

    // R6 / R7: interrupts only come from enabled periodic or one-shot cycles
    p_irq_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(en && (mode == MODE_PERIODIC || mode == MODE_ONESHOT)));

    // R8: a reset request only follows an enabled watchdog cycle, flag is set
    p_wdt_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wrst |-> ($past(en && mode == MODE_WDOG) && flag));

    // R10: the cause flag only falls after a write-one-to-clear
    p_cause_w1c_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> $past(w_stat && wbit_cause));

    // R7: enable only drops through a control write, one-shot expiry or system reset
    p_en_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en) |-> $past(w_ctrl || mode == MODE_ONESHOT || sys_rst));

    // R3: a disabled counter with no load write keeps its value
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !w_load && !sys_rst) |=> $stable(count));
endmodule

bind mt_timer mt_timer_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk_i),
    .rst_n      (rst_ni),
    .sys_rst    (sys_rst_i),
    .sel        (bus_sel_i),
    .wr         (bus_wr_i),
    .addr       (bus_addr_i),
    .wbit_cause (bus_wdata_i[5]),
    .irq        (irq_o),
    .wrst       (wdt_rst_req_o),
    .en         (ctrl_en),
    .mode       (ctrl_mode),
    .count      (cnt_val),
    .flag       (cause_flag)
);

// File: tb/mt_timer_tb_top.sv
module mt_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sys_rst = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        irq, wrst;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    // 250 MHz
    always #2 clk = ~clk;

    mt_timer dut_i (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .sys_rst_i     (sys_rst),
        .bus_sel_i     (bus_sel),
        .bus_wr_i      (bus_wr),
        .bus_addr_i    (bus_addr),
        .bus_wdata_i   (bus_wdata),
        .bus_rdata_o   (bus_rdata),
        .irq_o         (irq),
        .wdt_rst_req_o (wrst)
    );

    // Behavioural reference model
    int m_load, m_count, m_en, m_mode, m_psc, m_flag, m_irq, m_rst, m_ecyc;
    int div, n_load, n_count, n_en, n_mode, n_psc, n_flag, n_irq, n_rst;
    bit tick;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_load = 0; m_count = 0; m_en = 0; m_mode = 0; m_psc = 0;
            m_flag = 0; m_irq = 0; m_rst = 0; m_ecyc = 0;
        end else begin
            div  = (m_psc == 15) ? 65536 : (1 << m_psc);
            tick = (m_en != 0) && ((m_ecyc % div) == div - 1);
            n_load = m_load; n_count = m_count; n_en = m_en; n_mode = m_mode;
            n_psc = m_psc; n_flag = m_flag; n_irq = 0; n_rst = 0;
            if (tick) begin
                if (m_count > 0) n_count = m_count - 1;
                else if (m_mode == 0) n_count = 65535;
                else if (m_mode == 1) begin n_count = m_load; n_irq = 1; end
                else if (m_mode == 2) begin n_irq = 1; n_en = 0; end
                else begin n_rst = 1; n_flag = 1; n_count = m_load; end
            end
            if (bus_sel && bus_wr && bus_addr == 4'h0) begin
                n_load = int'(bus_wdata[15:0]); n_count = n_load;
            end
            if (bus_sel && bus_wr && bus_addr == 4'h8) begin
                n_en = int'(bus_wdata[7]); n_mode = int'(bus_wdata[5:4]);
                n_psc = int'(bus_wdata[3:0]);
            end
            if (bus_sel && bus_wr && bus_addr == 4'h4 && bus_wdata[5] && n_rst == 0)
                n_flag = 0;
            m_ecyc = (m_en != 0) ? (m_ecyc + 1) % 65536 : 0;
            if (sys_rst) begin
                n_load = 0; n_count = 0; n_en = 0; n_mode = 0; n_psc = 0;
                n_irq = 0; n_rst = 0; m_ecyc = 0;
            end
            m_load = n_load; m_count = n_count; m_en = n_en; m_mode = n_mode;
            m_psc = n_psc; m_flag = n_flag; m_irq = n_irq; m_rst = n_rst;
        end
    end

    function automatic logic [31:0] exp_rdata();
        case (bus_addr)
            4'h0: return 32'(m_count);
            4'h4: return 32'(m_flag) << 5;
            4'h8: return (32'(m_en) << 7) | (32'(m_mode) << 4) | 32'(m_psc);
            default: return 32'h0;
        endcase
    endfunction

    task automatic compare();
        logic [31:0] er;
        checks++;
        if (irq !== 1'(m_irq)) begin
            fails++;
            $display("FAIL %s irq at cycle %0d: got %0b expected %0d", cur_req, cyc, irq, m_irq);
        end
        checks++;
        if (wrst !== 1'(m_rst)) begin
            fails++;
            $display("FAIL %s reset request at cycle %0d: got %0b expected %0d", cur_req, cyc, wrst, m_rst);
        end
        if (bus_sel && !bus_wr) begin
            er = exp_rdata();
            checks++;
            if (bus_rdata !== er) begin
                fails++;
                $display("FAIL %s read 0x%0h at cycle %0d: got 0x%08h expected 0x%08h",
                         cur_req, bus_addr, cyc, bus_rdata, er);
            end
        end
    endtask

    task automatic step(input bit sel, input bit wr, input logic [3:0] a, input logic [31:0] d);
        bus_sel = sel; bus_wr = wr; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, 4'h0, 32'h0);
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
        step(1'b1, 1'b1, a, d);
    endtask

    task automatic rd_reg(input logic [3:0] a);
        step(1'b1, 1'b0, a, 32'h0);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: run reached %0d cycles, expected fewer than 190000", cyc);
            summary();
            $finish;
        end
    end

    initial begin
        // R1: power-on reset state
        cur_req = "R1";
        @(negedge clk);
        idle(3);
        rst_n = 1'b1;
        rd_reg(4'h0); rd_reg(4'h4); rd_reg(4'h8); rd_reg(4'hC);

        // R2: load write, upper bits dropped, counter readback
        cur_req = "R2";
        wr_reg(4'h0, 32'hABCD_1234);
        rd_reg(4'h0);
        idle(2);

        // R3: control fields, unused bits zero, disabled counter holds
        cur_req = "R3";
        wr_reg(4'h8, 32'hFFFF_FF3A);
        rd_reg(4'h8);
        idle(6);
        wr_reg(4'h8, 32'h0000_0000);

        // R5 with R4 code 0: free-running wrap
        cur_req = "R5";
        wr_reg(4'h8, 32'h00);
        wr_reg(4'h0, 32'h3);
        wr_reg(4'h8, 32'h80);
        idle(10);
        wr_reg(4'h8, 32'h00);
        idle(2);

        // R6 with R4 code 2: periodic reload and interrupt
        cur_req = "R6";
        wr_reg(4'h8, 32'h12);
        wr_reg(4'h0, 32'h2);
        wr_reg(4'h8, 32'h92);
        idle(30);
        wr_reg(4'h8, 32'h12);
        idle(3);

        // R7: one-shot stops itself
        cur_req = "R7";
        wr_reg(4'h8, 32'h21);
        wr_reg(4'h0, 32'h3);
        wr_reg(4'h8, 32'hA1);
        idle(14);
        rd_reg(4'h8);
        idle(3);

        // R8: watchdog expiry, request pulse, cause flag, reload
        cur_req = "R8";
        wr_reg(4'h8, 32'h30);
        wr_reg(4'h0, 32'h5);
        wr_reg(4'h8, 32'hB0);
        idle(15);
        rd_reg(4'h4);
        wr_reg(4'h8, 32'h30);

        // R10: write zero ignored, system reset keeps flag, write one clears
        cur_req = "R10";
        wr_reg(4'h4, 32'h0000_0000);
        rd_reg(4'h4);
        sys_rst = 1'b1;
        idle(1);
        sys_rst = 1'b0;
        rd_reg(4'h4); rd_reg(4'h8); rd_reg(4'h0);
        wr_reg(4'h4, 32'hFFFF_FFDF);
        rd_reg(4'h4);
        wr_reg(4'h4, 32'h20);
        rd_reg(4'h4);

        // R9: keepalive prevents reset requests
        cur_req = "R9";
        wr_reg(4'h8, 32'h30);
        wr_reg(4'h0, 32'h8);
        wr_reg(4'h8, 32'hB0);
        for (int i = 0; i < 8; i++) begin
            idle(5);
            wr_reg(4'h0, 32'h8);
        end
        rd_reg(4'h4);
        wr_reg(4'h8, 32'h30);

        // R11: writes on an expiry edge win over its effects
        cur_req = "R11";
        wr_reg(4'h8, 32'h20);
        wr_reg(4'h0, 32'h0);
        wr_reg(4'h8, 32'hA0);
        wr_reg(4'h8, 32'hA0);
        rd_reg(4'h8);
        idle(2);
        rd_reg(4'h8);
        wr_reg(4'h8, 32'h30);
        wr_reg(4'h0, 32'h0);
        wr_reg(4'h8, 32'hB0);
        wr_reg(4'h0, 32'h10);
        idle(4);
        wr_reg(4'h8, 32'h30);
        wr_reg(4'h4, 32'h20);

        // R4: largest divider code, one step per 65536 cycles
        cur_req = "R4";
        wr_reg(4'h8, 32'h0F);
        wr_reg(4'h0, 32'h5);
        wr_reg(4'h8, 32'h8F);
        idle(65545);
        wr_reg(4'h8, 32'h0F);
        idle(2);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule